// File: doc/BRIEF.md
# Self-Synchronizing 64b66b Block Scrambler Pair

This block holds a transmit scrambler and a receive descrambler for 66-bit line blocks. Each direction handles one 64-bit payload word per clock. It uses the self-synchronizing polynomial x^58 + x^39 + 1. Both directions unroll all 64 single-bit steps in combinational logic and register the result. The 2-bit sync header travels beside the word without being scrambled.

The scrambler feeds its own output bits into its 58-bit history. The descrambler feeds the received line bits into its history. Because of this, a descrambler that starts from any history value produces correct payload once 58 line bits have passed through it. The two directions are independent. In a loopback test the transmit outputs drive the receive inputs directly. Header handling beyond pass-through, gearboxing and block lock belong to neighbouring blocks.

Top module: `scr66_pair`

## Requirements
- R1: While rst_ni is low, tx_valid_o and rx_valid_o are 0, and tx_data_o, rx_data_o, tx_hdr_o and rx_hdr_o are all zero. The transmit history is loaded with TX_SEED and the receive history with RX_SEED.
- R2: Each valid output equals its valid input delayed by exactly one clock.
- R3: Scrambler law. Bits are processed from bit 63 down to bit 0. Output bit k = payload bit k XOR h[38] XOR h[57]. Here h is the history, h[0] is the most recent bit shifted in, and the scrambler shifts in each output bit after it forms it.
- R4: Descrambler law. Output bit k = received bit k XOR h[38] XOR h[57], with the same bit order. The descrambler shifts in each received bit, not each output bit.
- R5: In a cycle where a valid input is low, that direction's history and data/header outputs keep their values. The next valid word continues from the unchanged history.
- R6: The header output of each direction equals the header input of the last accepted word, with the same one-clock latency. The header never affects the data or the history.
- R7: Self-synchronization. With the scrambler outputs looped into the descrambler and TX_SEED different from RX_SEED, the descrambled payload equals the original payload in bits 5..0 of the first word and in all bits of every later word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_valid_i | input | 1 | Payload word present |
| tx_hdr_i | input | HDR_W | Sync header beside the payload |
| tx_data_i | input | DATA_W | Payload word to scramble |
| tx_valid_o | output | 1 | Scrambled word present |
| tx_hdr_o | output | HDR_W | Header carried unchanged |
| tx_data_o | output | DATA_W | Scrambled word |
| rx_valid_i | input | 1 | Line word present |
| rx_hdr_i | input | HDR_W | Received sync header |
| rx_data_i | input | DATA_W | Scrambled line word |
| rx_valid_o | output | 1 | Descrambled word present |
| rx_hdr_o | output | HDR_W | Header carried unchanged |
| rx_data_o | output | DATA_W | Recovered payload |

## Verification
The bench runs several payload patterns:
- An all-zero payload, which exposes the raw feedback sequence that grows from the seed.
- An all-ones payload and an alternating-bit payload, which catch swapped tap positions and a reversed bit order.
- Long random runs with random idle gaps, which test that the history holds during idle cycles.

A bench model checks both directions bit for bit. Separately, the looped-back payload is compared against the original. The two histories start from different seeds. This shows that the first word is wrong only in its upper 58 bits, and that every later word is exact.

// File: rtl/scr66_pkg.sv
package scr66_pkg;
  typedef enum logic {SCRAMBLE = 1'b0, DESCRAMBLE = 1'b1} scr_dir_e;
  localparam int unsigned DEF_DATA_W  = 64;
  localparam int unsigned DEF_STATE_W = 58;
  localparam int unsigned DEF_TAP     = 39;
  localparam int unsigned DEF_HDR_W   = 2;
endpackage

// File: rtl/scr66_unroll.sv
module scr66_unroll
  import scr66_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned STATE_W = DEF_STATE_W,
  parameter int unsigned TAP     = DEF_TAP,
  parameter scr_dir_e    DIR     = SCRAMBLE
) (
  input  logic [STATE_W-1:0] hist_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [DATA_W-1:0]  data_o,
  output logic [STATE_W-1:0] hist_o
);
  // MSB first; h[0] holds the most recent line bit
  if (DIR == DESCRAMBLE) begin : g_desc
    always_comb begin
      logic [STATE_W-1:0] h;
      h = hist_i;
      data_o = '0;
      for (int k = DATA_W - 1; k >= 0; k--) begin
        data_o[k] = data_i[k] ^ h[TAP-1] ^ h[STATE_W-1];
        h = {h[STATE_W-2:0], data_i[k]};
      end
      hist_o = h;
    end
  end else begin : g_scr
    always_comb begin
      logic [STATE_W-1:0] h;
      h = hist_i;
      data_o = '0;
      for (int k = DATA_W - 1; k >= 0; k--) begin
        data_o[k] = data_i[k] ^ h[TAP-1] ^ h[STATE_W-1];
        h = {h[STATE_W-2:0], data_o[k]};
      end
      hist_o = h;
    end
  end
endmodule

// File: rtl/scr66_lane.sv
module scr66_lane
  import scr66_pkg::*;
#(
  parameter int unsigned     DATA_W  = DEF_DATA_W,
  parameter int unsigned     STATE_W = DEF_STATE_W,
  parameter int unsigned     TAP     = DEF_TAP,
  parameter int unsigned     HDR_W   = DEF_HDR_W,
  parameter scr_dir_e        DIR     = SCRAMBLE,
  parameter logic [STATE_W-1:0] SEED = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [HDR_W-1:0]  hdr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [HDR_W-1:0]  hdr_o,
  output logic [DATA_W-1:0] data_o
);
  logic [STATE_W-1:0] hist_q, hist_d;
  logic [DATA_W-1:0]  word_d;

  scr66_unroll #(
    .DATA_W (DATA_W),
    .STATE_W(STATE_W),
    .TAP    (TAP),
    .DIR    (DIR)
  ) u_unroll (
    .hist_i(hist_q),
    .data_i(data_i),
    .data_o(word_d),
    .hist_o(hist_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= SEED;
      valid_o <= 1'b0;
      hdr_o   <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        hist_q <= hist_d;
        hdr_o  <= hdr_i;
        data_o <= word_d;
      end
    end
  end
endmodule

// File: rtl/scr66_pair.sv
module scr66_pair
  import scr66_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned STATE_W = DEF_STATE_W,
  parameter int unsigned TAP     = DEF_TAP,
  parameter int unsigned HDR_W   = DEF_HDR_W,
  parameter logic [STATE_W-1:0] TX_SEED = '1,
  parameter logic [STATE_W-1:0] RX_SEED = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_valid_i,
  input  logic [HDR_W-1:0]  tx_hdr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_valid_o,
  output logic [HDR_W-1:0]  tx_hdr_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              rx_valid_i,
  input  logic [HDR_W-1:0]  rx_hdr_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_valid_o,
  output logic [HDR_W-1:0]  rx_hdr_o,
  output logic [DATA_W-1:0] rx_data_o
);
  scr66_lane #(
    .DATA_W(DATA_W), .STATE_W(STATE_W), .TAP(TAP), .HDR_W(HDR_W),
    .DIR(SCRAMBLE), .SEED(TX_SEED)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(tx_valid_i),
    .hdr_i  (tx_hdr_i),
    .data_i (tx_data_i),
    .valid_o(tx_valid_o),
    .hdr_o  (tx_hdr_o),
    .data_o (tx_data_o)
  );

  scr66_lane #(
    .DATA_W(DATA_W), .STATE_W(STATE_W), .TAP(TAP), .HDR_W(HDR_W),
    .DIR(DESCRAMBLE), .SEED(RX_SEED)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(rx_valid_i),
    .hdr_i  (rx_hdr_i),
    .data_i (rx_data_i),
    .valid_o(rx_valid_o),
    .hdr_o  (rx_hdr_o),
    .data_o (rx_data_o)
  );
endmodule

// File: rtl/scr66_pair_chk.sv
module scr66_pair_chk #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned STATE_W = 58,
  parameter int unsigned TAP     = 39,
  parameter int unsigned HDR_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_valid_i,
  input logic [HDR_W-1:0]  tx_hdr_i,
  input logic [DATA_W-1:0] tx_data_i,
  input logic              tx_valid_o,
  input logic [HDR_W-1:0]  tx_hdr_o,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              rx_valid_i,
  input logic [HDR_W-1:0]  rx_hdr_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic              rx_valid_o,
  input logic [HDR_W-1:0]  rx_hdr_o,
  input logic [DATA_W-1:0] rx_data_o
);
  // low bits whose taps both fall inside the same word
  localparam int unsigned SPAN = DATA_W - STATE_W;

  // R2
  tx_valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o == $past(tx_valid_i));
  // R2
  rx_valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o == $past(rx_valid_i));
  // R5
  tx_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_i |=> $stable(tx_data_o) && $stable(tx_hdr_o));
  // R5
  rx_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(rx_data_o) && $stable(rx_hdr_o));
  // R6
  tx_hdr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> tx_hdr_o == $past(tx_hdr_i));
  // R6
  rx_hdr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> rx_hdr_o == $past(rx_hdr_i));
  // R3
  tx_self_tap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> (tx_data_o[SPAN-1:0] ^ $past(tx_data_i[SPAN-1:0])
                    ^ tx_data_o[TAP+SPAN-1:TAP]
                    ^ tx_data_o[STATE_W+SPAN-1:STATE_W]) == '0);
  // R4
  rx_line_tap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> (rx_data_o[SPAN-1:0] ^ $past(rx_data_i[SPAN-1:0])
                    ^ $past(rx_data_i[TAP+SPAN-1:TAP])
                    ^ $past(rx_data_i[STATE_W+SPAN-1:STATE_W])) == '0);
endmodule

bind scr66_pair scr66_pair_chk #(
  .DATA_W(DATA_W), .STATE_W(STATE_W), .TAP(TAP), .HDR_W(HDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_valid_i(tx_valid_i),
  .tx_hdr_i  (tx_hdr_i),
  .tx_data_i (tx_data_i),
  .tx_valid_o(tx_valid_o),
  .tx_hdr_o  (tx_hdr_o),
  .tx_data_o (tx_data_o),
  .rx_valid_i(rx_valid_i),
  .rx_hdr_i  (rx_hdr_i),
  .rx_data_i (rx_data_i),
  .rx_valid_o(rx_valid_o),
  .rx_hdr_o  (rx_hdr_o),
  .rx_data_o (rx_data_o)
);

// File: tb/scr66_pair_bench.sv
module scr66_pair_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [57:0] TX_SEED = 58'h2A5_F00D_C0DE_1234;
  localparam logic [57:0] RX_SEED = 58'h013_3333_9999_0F0F;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_valid_i = 1'b0;
  logic [1:0]  tx_hdr_i = '0;
  logic [63:0] tx_data_i = '0;
  logic        tx_valid_o, rx_valid_o, rx_valid_i;
  logic [1:0]  tx_hdr_o, rx_hdr_o, rx_hdr_i;
  logic [63:0] tx_data_o, rx_data_o, rx_data_i;

  // back-to-back loop
  assign rx_valid_i = tx_valid_o;
  assign rx_hdr_i   = tx_hdr_o;
  assign rx_data_i  = tx_data_o;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  scr66_pair #(.TX_SEED(TX_SEED), .RX_SEED(RX_SEED)) u_scr66_pair (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tx_valid_i(tx_valid_i), .tx_hdr_i(tx_hdr_i), .tx_data_i(tx_data_i),
    .tx_valid_o(tx_valid_o), .tx_hdr_o(tx_hdr_o), .tx_data_o(tx_data_o),
    .rx_valid_i(rx_valid_i), .rx_hdr_i(rx_hdr_i), .rx_data_i(rx_data_i),
    .rx_valid_o(rx_valid_o), .rx_hdr_o(rx_hdr_o), .rx_data_o(rx_data_o)
  );

  int unsigned n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [57:0] m_txh, m_rxh;
  logic        e_tx_v, e_rx_v;
  logic [1:0]  e_tx_h, e_rx_h;
  logic [63:0] e_tx_d, e_rx_d, e_tx_pay, e_rx_pay;
  int unsigned rx_words;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // returns {new_history, word}; MSB first, taps h[38], h[57]
  function automatic logic [121:0] ref_step(input bit desc, input logic [57:0] h,
                                            input logic [63:0] d);
    logic [63:0] o;
    logic [57:0] s;
    s = h;
    o = '0;
    for (int k = 63; k >= 0; k--) begin
      o[k] = d[k] ^ s[38] ^ s[57];
      s = {s[56:0], desc ? d[k] : o[k]};
    end
    return {s, o};
  endfunction

  task automatic run_cycle(input logic v, input logic [1:0] h, input logic [63:0] d);
    logic [121:0] r;
    tx_valid_i = v;
    tx_hdr_i   = h;
    tx_data_i  = d;
    // rx sees the word tx presented last cycle
    if (e_tx_v) begin
      r = ref_step(1'b1, m_rxh, e_tx_d);
      m_rxh = r[121:64];
      e_rx_d = r[63:0];
      e_rx_h = e_tx_h;
      e_rx_pay = e_tx_pay;
    end
    e_rx_v = e_tx_v;
    if (v) begin
      r = ref_step(1'b0, m_txh, d);
      m_txh = r[121:64];
      e_tx_d = r[63:0];
      e_tx_h = h;
      e_tx_pay = d;
    end
    e_tx_v = v;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(tx_valid_o == e_tx_v, "R2 tx valid", 64'(tx_valid_o), 64'(e_tx_v));
    chk(rx_valid_o == e_rx_v, "R2 rx valid", 64'(rx_valid_o), 64'(e_rx_v));
    chk(tx_data_o == e_tx_d, v ? "R3 tx data" : "R5 tx hold", tx_data_o, e_tx_d);
    chk(tx_hdr_o == e_tx_h, "R6 tx hdr", 64'(tx_hdr_o), 64'(e_tx_h));
    chk(rx_data_o == e_rx_d, e_rx_v ? "R4 rx data" : "R5 rx hold", rx_data_o, e_rx_d);
    chk(rx_hdr_o == e_rx_h, "R6 rx hdr", 64'(rx_hdr_o), 64'(e_rx_h));
    if (e_rx_v) begin
      if (rx_words == 0)
        chk(rx_data_o[5:0] == e_rx_pay[5:0], "R7 first word low bits",
            64'(rx_data_o[5:0]), 64'(e_rx_pay[5:0]));
      else
        chk(rx_data_o == e_rx_pay, "R7 payload recovered", rx_data_o, e_rx_pay);
      rx_words++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    m_txh = TX_SEED; m_rxh = RX_SEED;
    e_tx_v = 0; e_rx_v = 0; e_tx_h = 0; e_rx_h = 0;
    e_tx_d = 0; e_rx_d = 0; e_tx_pay = 0; e_rx_pay = 0;
    rx_words = 0;
    repeat (3) @(negedge clk_i);
    // R1: outputs during reset
    chk(tx_valid_o == 1'b0 && rx_valid_o == 1'b0, "R1 valid in reset",
        64'({tx_valid_o, rx_valid_o}), 64'd0);
    chk(tx_data_o == '0 && rx_data_o == '0 && tx_hdr_o == '0 && rx_hdr_o == '0,
        "R1 data in reset", tx_data_o | rx_data_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // directed patterns
    for (int i = 0; i < 3; i++) run_cycle(1'b1, 2'b01, 64'h0);
    run_cycle(1'b1, 2'b10, '1);
    run_cycle(1'b1, 2'b10, '1);
    run_cycle(1'b1, 2'b01, 64'hAAAA_AAAA_AAAA_AAAA);
    run_cycle(1'b1, 2'b01, 64'h5555_5555_5555_5555);
    for (int i = 0; i < 5; i++) run_cycle(1'b0, 2'b11, 64'hDEAD_BEEF_0000_FFFF);
    run_cycle(1'b1, 2'b10, 64'h8000_0000_0000_0001);
    // random traffic with idle gaps
    for (int i = 0; i < 3000; i++) begin
      logic v;
      v = ($urandom % 4) != 0;
      run_cycle(v, 2'($urandom), {$urandom, $urandom});
    end
    for (int i = 0; i < 3; i++) run_cycle(1'b0, 2'b00, 64'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule